// File: doc/BRIEF.md
# Pixel Denormalize and Clamp Stage

This stage sits at the tail of a display pixel pipe. It takes three colour components in normalized unsigned fixed-point form (U1.15: bit 15 is the integer bit, so 1.0 is `0x8000`) and turns each one into an integer code for an output depth of 8, 10 or 12 bits. A two-bit mode selects the depth. The stage multiplies by (2^N-1)/2^N and rounds, so a normalized 1.0 lands exactly on the top code of the chosen depth instead of overflowing or truncating one step short.

After scaling, each component is held inside a legal window. The window is either the full range of the depth or a per-component pair of programmed bounds. A format flag can repack the result into a 10-bit field for a downstream link that carries 10 bits whatever the depth. Mode, flag and bounds travel with each pixel, so settings can change between pixels without bubbles. The result appears two clocks after the input, with its valid.

Top module: `pix_denorm_clamp`

## Requirements
- R1: With mode 1, 2 or 3 (8, 10 or 12 bits), an input of exactly 1.0 (`0x8000`) gives 255, 1023 or 4095 respectively.
- R2: In modes 1 to 3 the code is x*(2^N-1)/2^15 rounded to nearest, with an exact half rounded up (mode 2, x=`0x4000` gives 512; mode 1, x=`0x0040` gives 0 and x=`0x0080` gives 1).
- R3: Mode 0 applies no scale factor: the code is x shifted right by 3 (the input truncated to 12 bits) and is treated as 12-bit depth.
- R4: With the bound enable low, every code is clamped to the range 0 to the top code of the depth (mode 1, x=`0xFFFF` gives 255; mode 0, x=`0xFFFF` gives 4095).
- R5: With the bound enable high, each component is clamped to its own programmed lower and upper bound. The upper bound is first capped at the top code of the depth.
- R6: When a programmed lower bound exceeds the effective upper bound, the upper bound wins.
- R7: With the 10-bit flag set, 8-bit codes are shifted left by 2 and 10-bit codes pass unchanged. 12-bit codes (modes 0 and 3) become (c+2)>>2, saturated at 1023. Bits 11:10 of each output field are then zero.
- R8: A pixel presented with `in_vld` high appears on `out_pix` with `out_vld` high exactly two rising edges later. `out_vld` is low two edges after a cycle without `in_vld`.
- R9: Cycles without `in_vld` leave `out_pix` unchanged, whatever the other inputs do.
- R10: Mode, 10-bit flag, bound enable and bounds are sampled with each valid pixel, so back-to-back pixels may each use different settings.
- R11: The three components are processed independently. Component k occupies bits [16k+15:16k] of `in_pix` and [12k+11:12k] of `out_pix` and of each bound bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input pixel valid |
| in_pix | input | 48 | Three U1.15 components |
| dn_mode | input | 2 | 0 bypass, 1 eight-bit, 2 ten-bit, 3 twelve-bit |
| out10_en | input | 1 | Repack the result into a 10-bit field |
| bound_en | input | 1 | Use the programmed bounds instead of the full range |
| bound_lo | input | 36 | Per-component lower bounds |
| bound_hi | input | 36 | Per-component upper bounds |
| out_vld | output | 1 | Output pixel valid |
| out_pix | output | 36 | Three output codes |

## Verification
Two functions can act on one component in the same cycle: the rounding of the scale step and the saturation of the 10-bit repack. A 12-bit input of 1.0 with the flag set gives 4095, which rounds up to 1024 and must be saturated to 1023. Bounds clamping and the mode-dependent cap on the upper bound also meet in one cycle when a programmed upper bound lies above the depth's range. Both cases are provoked with directed pixels whose expected codes are worked out by hand. A burst of back-to-back pixels then changes mode and flag on every pixel, to show that each setting stays with its own pixel through both stages.

// File: rtl/pix_denorm_pkg.sv
package pix_denorm_pkg;

  localparam int unsigned CODE_W = 12;

  typedef enum logic [1:0] {
    DN_PASS = 2'd0,
    DN_8    = 2'd1,
    DN_10   = 2'd2,
    DN_12   = 2'd3
  } dn_mode_e;

  function automatic logic [CODE_W-1:0] mode_max(input dn_mode_e m);
    case (m)
      DN_8:    mode_max = 12'd255;
      DN_10:   mode_max = 12'd1023;
      default: mode_max = 12'd4095;
    endcase
  endfunction

endpackage

// File: rtl/dn_scale.sv
module dn_scale
  import pix_denorm_pkg::*;
#(
  parameter int unsigned IN_W   = 16,
  parameter int unsigned FRAC_W = 15,
  localparam int unsigned PRE_W = IN_W - FRAC_W + CODE_W
) (
  input  logic [IN_W-1:0]  x,
  input  dn_mode_e         mode,
  output logic [PRE_W-1:0] code
);
  localparam int unsigned PROD_W = IN_W + CODE_W;
  localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] rnd;
  logic [IN_W-1:0]   trunc;

  always_comb begin
    prod  = PROD_W'(x) * PROD_W'(mode_max(mode));
    rnd   = prod + HALF;
    trunc = x >> (FRAC_W - CODE_W);
    if (mode == DN_PASS) code = trunc[PRE_W-1:0];
    else                 code = rnd[FRAC_W +: PRE_W];
  end

endmodule

// File: rtl/dn_limit.sv
module dn_limit
  import pix_denorm_pkg::*;
#(
  parameter int unsigned PRE_W = 13
) (
  input  logic [PRE_W-1:0]  code,
  input  logic [PRE_W-1:0]  lo,
  input  logic [PRE_W-1:0]  hi,
  input  dn_mode_e          mode,
  input  logic              out10,
  output logic [CODE_W-1:0] res
);
  logic [PRE_W-1:0]  v_lo;
  logic [PRE_W-1:0]  v_hi;
  logic [CODE_W:0]   r12;
  logic [CODE_W-2:0] q12;

  always_comb begin
    v_lo = (code < lo) ? lo : code;
    v_hi = (v_lo > hi) ? hi : v_lo;
    r12  = {1'b0, v_hi[CODE_W-1:0]} + 13'd2;
    q12  = r12[CODE_W:2];
    if (!out10) begin
      res = v_hi[CODE_W-1:0];
    end else begin
      case (mode)
        DN_8:    res = {2'b00, v_hi[7:0], 2'b00};
        DN_10:   res = {2'b00, v_hi[9:0]};
        default: res = (q12 > 11'd1023) ? 12'd1023 : {1'b0, q12};
      endcase
    end
  end

endmodule

// File: rtl/pix_denorm_clamp.sv
module pix_denorm_clamp
  import pix_denorm_pkg::*;
#(
  parameter int unsigned IN_W   = 16,
  parameter int unsigned FRAC_W = 15,
  parameter int unsigned NCOMP  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic [NCOMP*IN_W-1:0]   in_pix,
  input  logic [1:0]              dn_mode,
  input  logic                    out10_en,
  input  logic                    bound_en,
  input  logic [NCOMP*CODE_W-1:0] bound_lo,
  input  logic [NCOMP*CODE_W-1:0] bound_hi,
  output logic                    out_vld,
  output logic [NCOMP*CODE_W-1:0] out_pix
);
  localparam int unsigned PRE_W = IN_W - FRAC_W + CODE_W;
  localparam logic [IN_W-1:0] ONE = IN_W'(1) << FRAC_W;

  dn_mode_e mode_in;
  assign mode_in = dn_mode_e'(dn_mode);

  // stage 1 state
  logic     s1_vld;
  dn_mode_e s1_mode;
  logic     s1_out10;
  logic [NCOMP*PRE_W-1:0] s1_code_d, s1_code_q;
  logic [NCOMP*PRE_W-1:0] s1_lo_d,   s1_lo_q;
  logic [NCOMP*PRE_W-1:0] s1_hi_d,   s1_hi_q;
  // stage 2 next state
  logic [NCOMP*CODE_W-1:0] s2_pix_d;
  // monitor copies of the settings that produced out_pix
  dn_mode_e mon_mode;
  logic     mon_out10;

  logic [CODE_W-1:0] cap_max;
  assign cap_max = mode_max(mode_in);

  for (genvar k = 0; k < NCOMP; k++) begin : g_comp
    logic [CODE_W-1:0] hi_cap;

    dn_scale #(.IN_W(IN_W), .FRAC_W(FRAC_W)) i_scale (
      .x    (in_pix[k*IN_W +: IN_W]),
      .mode (mode_in),
      .code (s1_code_d[k*PRE_W +: PRE_W])
    );

    always_comb begin
      hi_cap = (bound_hi[k*CODE_W +: CODE_W] > cap_max) ? cap_max
                                                         : bound_hi[k*CODE_W +: CODE_W];
      s1_hi_d[k*PRE_W +: PRE_W] = bound_en ? PRE_W'(hi_cap) : PRE_W'(cap_max);
      s1_lo_d[k*PRE_W +: PRE_W] = bound_en ? PRE_W'(bound_lo[k*CODE_W +: CODE_W])
                                           : '0;
    end

    dn_limit #(.PRE_W(PRE_W)) i_limit (
      .code  (s1_code_q[k*PRE_W +: PRE_W]),
      .lo    (s1_lo_q[k*PRE_W +: PRE_W]),
      .hi    (s1_hi_q[k*PRE_W +: PRE_W]),
      .mode  (s1_mode),
      .out10 (s1_out10),
      .res   (s2_pix_d[k*CODE_W +: CODE_W])
    );
  end

  // stage 1 registers, enabled by input valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_mode   <= DN_PASS;
      s1_out10  <= 1'b0;
      s1_code_q <= '0;
      s1_lo_q   <= '0;
      s1_hi_q   <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_mode   <= mode_in;
        s1_out10  <= out10_en;
        s1_code_q <= s1_code_d;
        s1_lo_q   <= s1_lo_d;
        s1_hi_q   <= s1_hi_d;
      end
    end
  end

  // stage 2 registers, enabled by stage 1 valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      out_pix   <= '0;
      mon_mode  <= DN_PASS;
      mon_out10 <= 1'b0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) begin
        out_pix   <= s2_pix_d;
        mon_mode  <= s1_mode;
        mon_out10 <= s1_out10;
      end
    end
  end

  // R1: exact 1.0 on component 0 reaches the top code two edges later
  p_one_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && mode_in != DN_PASS && !bound_en && !out10_en &&
     in_pix[IN_W-1:0] == ONE)
    |-> ##2 (out_pix[CODE_W-1:0] == mode_max(mon_mode)));

  // R4: zero input without bounds gives code zero
  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !bound_en && in_pix[IN_W-1:0] == '0)
    |-> ##2 (out_pix[CODE_W-1:0] == '0));

  // R4: unformatted output never exceeds the depth's top code
  p_below_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !mon_out10) |-> (out_pix[CODE_W-1:0] <= mode_max(mon_mode)));

  // R7: 10-bit field keeps its two top bits clear
  p_out10_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && mon_out10) |-> (out_pix[CODE_W-1 -: 2] == 2'b00));

  // R8: valid travels with a two-edge delay
  p_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ##2 out_vld);
  p_novld_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |-> ##2 !out_vld);

  // R9: output data holds when no pixel moves into stage 2
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> $stable(out_pix));

endmodule

// File: tb/test_pix_denorm_clamp.sv
`timescale 1ns/1ps
module test_pix_denorm_clamp;

  logic        clk;
  logic        rst_n;
  logic        in_vld;
  logic [47:0] in_pix;
  logic [1:0]  dn_mode;
  logic        out10_en;
  logic        bound_en;
  logic [35:0] bound_lo;
  logic [35:0] bound_hi;
  logic        out_vld;
  logic [35:0] out_pix;

  int n_chk;
  int n_bad;
  bit done;

  pix_denorm_clamp i_pix_denorm_clamp (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_pix(in_pix),
    .dn_mode(dn_mode), .out10_en(out10_en), .bound_en(bound_en),
    .bound_lo(bound_lo), .bound_hi(bound_hi),
    .out_vld(out_vld), .out_pix(out_pix)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int comp(input int k);
    return int'(out_pix[k*12 +: 12]);
  endfunction

  // expected code from the requirements
  function automatic int model(input int x, input int m, input bit o10,
                               input bit be, input int lo, input int hi);
    int mx, c, h, l;
    mx = (m == 1) ? 255 : (m == 2) ? 1023 : 4095;
    if (m == 0) c = x >> 3;
    else        c = (x * mx + 16384) >>> 15;
    h = be ? ((hi > mx) ? mx : hi) : mx;
    l = be ? lo : 0;
    if (c < l) c = l;
    if (c > h) c = h;
    if (o10) begin
      if (m == 1)      c = c << 2;
      else if (m != 2) begin c = (c + 2) >> 2; if (c > 1023) c = 1023; end
    end
    return c;
  endfunction

  task automatic setup(input int x0, input int x1, input int x2, input int m,
                       input bit o10, input bit be, input int lo, input int hi);
    in_pix   = {16'(x2), 16'(x1), 16'(x0)};
    dn_mode  = 2'(m);
    out10_en = o10;
    bound_en = be;
    bound_lo = {3{12'(lo)}};
    bound_hi = {3{12'(hi)}};
  endtask

  // one pixel in, result sampled two edges later
  task automatic send(input int x0, input int x1, input int x2, input int m,
                      input bit o10, input bit be, input int lo, input int hi);
    @(negedge clk);
    setup(x0, x1, x2, m, o10, be, lo, hi);
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R8 reset out_vld", int'(out_vld), 0);
    chk("R8 reset out_pix", int'(out_pix != 0), 0);
  endtask

  task automatic t_unit;
    send(16'h8000, 16'h8000, 16'h8000, 1, 0, 0, 0, 0);
    chk("R1 8-bit one", comp(0), 255);
    send(16'h8000, 0, 0, 2, 0, 0, 0, 0);
    chk("R1 10-bit one", comp(0), 1023);
    send(16'h8000, 0, 0, 3, 0, 0, 0, 0);
    chk("R1 12-bit one", comp(0), 4095);
  endtask

  task automatic t_round;
    send(16'h4000, 16'h0040, 16'h0080, 2, 0, 0, 0, 0);
    chk("R2 half up 10-bit", comp(0), 512);
    send(16'h4000, 16'h0040, 16'h0080, 1, 0, 0, 0, 0);
    chk("R2 below half", comp(1), 0);
    chk("R2 at half", comp(2), 1);
  endtask

  task automatic t_bypass;
    send(16'h1238, 16'hFFFF, 0, 0, 0, 0, 0, 0);
    chk("R3 bypass truncate", comp(0), 16'h1238 >> 3);
    chk("R4 bypass clamp", comp(1), 4095);
  endtask

  task automatic t_clamp;
    send(16'hFFFF, 0, 0, 1, 0, 0, 0, 0);
    chk("R4 8-bit over range", comp(0), 255);
    chk("R4 zero", comp(1), 0);
  endtask

  task automatic t_bounds;
    send(0, 16'h8000, 16'h4000, 1, 0, 1, 16, 235);
    chk("R5 lower bound", comp(0), 16);
    chk("R5 upper bound", comp(1), 235);
    chk("R5 inside", comp(2), 128);
    send(16'hFFFF, 0, 0, 1, 0, 1, 0, 4095);
    chk("R5 upper capped", comp(0), 255);
    send(0, 16'h8000, 0, 1, 0, 1, 200, 100);
    chk("R6 upper wins low", comp(0), 100);
    chk("R6 upper wins high", comp(1), 100);
  endtask

  task automatic t_out10;
    send(16'h8000, 16'h0080, 0, 1, 1, 0, 0, 0);
    chk("R7 8-bit justify", comp(0), 1020);
    chk("R7 8-bit small", comp(1), 4);
    send(16'h8000, 0, 0, 2, 1, 0, 0, 0);
    chk("R7 10-bit as is", comp(0), 1023);
    send(16'h8000, 16'h4000, 16, 3, 1, 0, 0, 0);
    chk("R7 12-bit saturate", comp(0), 1023);
    chk("R7 12-bit round", comp(1), 512);
    chk("R7 12-bit half", comp(2), 1);
    send(16'hFFFF, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 bypass saturate", comp(0), 1023);
  endtask

  task automatic t_latency;
    @(negedge clk);
    setup(16'h8000, 0, 0, 1, 0, 0, 0, 0);
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    chk("R8 not after one edge", int'(out_vld), 0);
    @(negedge clk);
    chk("R8 valid after two", int'(out_vld), 1);
    chk("R8 data after two", comp(0), 255);
    @(negedge clk);
    chk("R8 valid drops", int'(out_vld), 0);
  endtask

  task automatic t_hold;
    int keep;
    send(16'h2000, 16'h3000, 16'h5000, 2, 0, 0, 0, 0);
    keep = comp(2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      setup(16'hFFFF, 16'hFFFF, 16'hFFFF, 3, 1, 1, 7, 9);
    end
    chk("R9 hold comp0", comp(0), model(16'h2000, 2, 0, 0, 0, 0));
    chk("R9 hold comp2", comp(2), keep);
    chk("R9 no valid", int'(out_vld), 0);
  endtask

  task automatic t_independent;
    send(16'h1000, 16'h6000, 16'hC000, 2, 0, 0, 0, 0);
    chk("R11 comp0", comp(0), model(16'h1000, 2, 0, 0, 0, 0));
    chk("R11 comp1", comp(1), model(16'h6000, 2, 0, 0, 0, 0));
    chk("R11 comp2", comp(2), model(16'hC000, 2, 0, 0, 0, 0));
  endtask

  task automatic t_stream;
    int xs[6] = '{16'h8000, 16'h4000, 16'h7FFF, 16'h1234, 16'hFFFF, 16'h0C00};
    int ms[6] = '{1, 3, 2, 0, 3, 1};
    bit os[6] = '{0, 1, 0, 1, 1, 1};
    bit bs[6] = '{0, 0, 1, 0, 1, 0};
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        chk("R10 stream valid", int'(out_vld), 1);
        chk("R10 stream data", comp(0),
            model(xs[k-2], ms[k-2], os[k-2], bs[k-2], 20, 900));
      end
      if (k < 6) begin
        setup(xs[k], 0, 0, ms[k], os[k], bs[k], 20, 900);
        in_vld = 1'b1;
      end else begin
        in_vld = 1'b0;
      end
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; in_vld = 1'b0;
    setup(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_unit();
    t_round();
    t_bypass();
    t_clamp();
    t_bounds();
    t_out10();
    t_latency();
    t_hold();
    t_independent();
    t_stream();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule